// File: doc/BRIEF.md
# Limited-Pointer Sharer Tracker

This block keeps, for a small table of memory blocks, the set of cores that currently hold a read copy of each block. A full presence vector would need one bit per core per block. Each entry here instead holds a few slots, and each slot is a core-index pointer with its own valid bit. A coherence controller sends it four kinds of command: record a sharer, forget a sharer, wipe an entry, and list an entry's targets for invalidation.

An entry can fill all of its slots. When one more distinct core is then recorded, the entry becomes saturated. From then on, any listing names every core in the system, because the exact sharer set is no longer known. Saturation is cleared only by wiping the entry.

A listing appears as a stream of core indices under a valid/ready handshake. The stream gives one index per accepted cycle in ascending order, and it can optionally leave out the requesting core. A one-cycle completion strobe follows the stream and carries the number of indices emitted, so the controller knows how many acknowledgements to wait for.

Top module: `sharer_tracker`

## Requirements
- R1: After reset every entry is empty and not saturated: a listing of any entry emits no index and completes with a count of 0.
- R2: A record command (cmd_op = 0) for a core that the entry does not yet hold, on an entry that has a free slot and is not saturated, stores that core so that later listings include it.
- R3: A record command for a core the entry already holds changes nothing and uses no slot: K_SLOTS distinct cores fit in an entry however often each one is recorded.
- R4: A record command for a new distinct core on an entry whose K_SLOTS slots are all occupied makes the entry saturated. A listing of a saturated entry emits every index 0 to N_CORES-1.
- R5: A forget command (cmd_op = 1) frees the slot that holds the given core, and a later record can reuse that slot. Forgetting a core the entry does not hold has no effect.
- R6: An entry stays saturated through forget and record commands until a wipe command (cmd_op = 2) empties all its slots and returns it to normal mode.
- R7: A listing (cmd_op = 3) emits the target indices in strictly ascending order, one per cycle in which tgt_ready is high. tgt_valid stays high from the first cycle after the listing is accepted until the last index is taken. While tgt_ready is low, tgt_id holds its value.
- R8: When cmd_skip is set with a listing, the core given on cmd_core is left out of the stream, both in normal mode and in saturated mode.
- R9: done is high for exactly one cycle. It rises on the second clock edge after the final handshake, or on the second edge after a listing with no targets is accepted. done_count then equals the number of indices emitted.
- R10: cmd_ready is low from the edge that accepts a listing until done is raised. A command changes only the entry that cmd_entry selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be accepted (low while a listing runs) |
| cmd_op | input | 2 | 0 record, 1 forget, 2 wipe, 3 list |
| cmd_entry | input | ENTRY_W | Entry (block) index |
| cmd_core | input | PTR_W | Core index for record/forget; requester for list |
| cmd_skip | input | 1 | Leave the requester out of a listing |
| tgt_valid | output | 1 | A target index is offered |
| tgt_ready | input | 1 | Consumer takes the offered index |
| tgt_id | output | PTR_W | Target core index |
| done | output | 1 | One-cycle completion strobe of a listing |
| done_count | output | CNT_W | Number of indices emitted by that listing |

## Verification
The bench first runs directed sequences on a configuration with eight cores, three slots and four entries. One set of these fills an entry with repeats of the same core, which separates duplicate detection from plain slot counting. Another adds exactly one core past capacity, which shows where saturation begins. A third frees a slot and refills it, which tells slot reuse apart from a stuck slot. A fourth exercises forget and record on a saturated entry, which shows that saturation is sticky. Listings are run with and without the requester skipped. Some run with a consumer that takes every index and some with one that stalls on alternate cycles, which exposes both ordering faults and failures to hold the offered index. A long pseudo-random sequence of commands across all entries is then compared after every command against a set-and-flag model. That comparison catches cross-entry interference and mismatches in the completion timing or the count.

// File: rtl/sharer_tracker_pkg.sv
package sharer_tracker_pkg;
  typedef enum logic [1:0] {
    OP_ADD  = 2'd0,
    OP_DROP = 2'd1,
    OP_WIPE = 2'd2,
    OP_LIST = 2'd3
  } trk_op_e;
endpackage

// File: rtl/sharer_slot_match.sv
// Compares a core index against every slot of one entry and finds the
// lowest free slot.
module sharer_slot_match #(
  parameter int K_SLOTS = 4,
  parameter int PTR_W   = 4,
  parameter int SLOT_W  = (K_SLOTS > 1) ? $clog2(K_SLOTS) : 1
) (
  input  logic [K_SLOTS-1:0][PTR_W-1:0] slot_ids,
  input  logic [K_SLOTS-1:0]            slot_vld,
  input  logic [PTR_W-1:0]              core,
  output logic [K_SLOTS-1:0]            hit_vec,
  output logic                          hit,
  output logic                          free_any,
  output logic [SLOT_W-1:0]             free_idx
);

  for (genvar s = 0; s < K_SLOTS; s++) begin : g_cmp
    assign hit_vec[s] = slot_vld[s] && (slot_ids[s] == core);
  end

  assign hit      = |hit_vec;
  assign free_any = ~&slot_vld;

  always_comb begin
    free_idx = '0;
    for (int i = K_SLOTS - 1; i >= 0; i--) begin
      if (!slot_vld[i]) free_idx = SLOT_W'(i);
    end
  end

endmodule

// File: rtl/sharer_target_mask.sv
// Expands an entry (pointer slots or saturation flag) into a per-core target
// mask, optionally removing the requester.
module sharer_target_mask #(
  parameter int N_CORES = 16,
  parameter int K_SLOTS = 4,
  parameter int PTR_W   = 4
) (
  input  logic [K_SLOTS-1:0][PTR_W-1:0] slot_ids,
  input  logic [K_SLOTS-1:0]            slot_vld,
  input  logic                          saturated,
  input  logic                          skip,
  input  logic [PTR_W-1:0]              requester,
  output logic [N_CORES-1:0]            mask
);

  for (genvar c = 0; c < N_CORES; c++) begin : g_core
    logic [K_SLOTS-1:0] slot_hit;
    for (genvar s = 0; s < K_SLOTS; s++) begin : g_slot
      assign slot_hit[s] = slot_vld[s] && (slot_ids[s] == PTR_W'(c));
    end
    assign mask[c] = (saturated || (|slot_hit)) &&
                     !(skip && (requester == PTR_W'(c)));
  end

endmodule

// File: rtl/sharer_enum_seq.sv
// Streams the set bits of a loaded mask lowest-first, then strobes done
// with the number of handshakes.
module sharer_enum_seq #(
  parameter int N_CORES = 16,
  parameter int PTR_W   = 4,
  parameter int CNT_W   = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [N_CORES-1:0] load_mask,
  input  logic               tgt_ready,
  output logic               tgt_valid,
  output logic [PTR_W-1:0]   tgt_id,
  output logic               busy,
  output logic               done,
  output logic [CNT_W-1:0]   done_count
);

  logic [N_CORES-1:0] rem_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [PTR_W-1:0]   pick;

  always_comb begin
    pick = '0;
    for (int i = N_CORES - 1; i >= 0; i--) begin
      if (rem_q[i]) pick = PTR_W'(i);
    end
  end

  assign tgt_valid = busy && (|rem_q);
  assign tgt_id    = pick;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      rem_q      <= '0;
      cnt_q      <= '0;
      done       <= 1'b0;
      done_count <= '0;
    end else begin
      done <= 1'b0;
      if (load) begin
        busy  <= 1'b1;
        rem_q <= load_mask;
        cnt_q <= '0;
      end else if (busy) begin
        if (rem_q == '0) begin
          busy       <= 1'b0;
          done       <= 1'b1;
          done_count <= cnt_q;
        end else if (tgt_ready) begin
          rem_q[pick] <= 1'b0;
          cnt_q       <= cnt_q + CNT_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/sharer_tracker.sv
module sharer_tracker
  import sharer_tracker_pkg::*;
#(
  parameter int  N_CORES   = 16,
  parameter int  K_SLOTS   = 4,
  parameter int  N_ENTRIES = 8,
  localparam int PTR_W     = (N_CORES > 1) ? $clog2(N_CORES) : 1,
  localparam int ENTRY_W   = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1,
  localparam int CNT_W     = $clog2(N_CORES + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [1:0]         cmd_op,
  input  logic [ENTRY_W-1:0] cmd_entry,
  input  logic [PTR_W-1:0]   cmd_core,
  input  logic               cmd_skip,
  output logic               tgt_valid,
  input  logic               tgt_ready,
  output logic [PTR_W-1:0]   tgt_id,
  output logic               done,
  output logic [CNT_W-1:0]   done_count
);

  localparam int SLOT_W = (K_SLOTS > 1) ? $clog2(K_SLOTS) : 1;

  logic [K_SLOTS-1:0][PTR_W-1:0] ids_q [N_ENTRIES];
  logic [K_SLOTS-1:0]            vld_q [N_ENTRIES];
  logic [N_ENTRIES-1:0]          sat_q;

  logic [K_SLOTS-1:0][PTR_W-1:0] cur_ids;
  logic [K_SLOTS-1:0]            cur_vld;
  logic                          cur_sat;
  logic [K_SLOTS-1:0]            hit_vec;
  logic                          hit;
  logic                          free_any;
  logic [SLOT_W-1:0]             free_idx;
  logic [N_CORES-1:0]            list_mask;
  logic                          seq_busy;
  logic                          fire;
  logic                          do_store;
  trk_op_e                       op;

  assign op        = trk_op_e'(cmd_op);
  assign cmd_ready = !seq_busy;
  assign fire      = cmd_valid && cmd_ready;
  assign cur_ids   = ids_q[cmd_entry];
  assign cur_vld   = vld_q[cmd_entry];
  assign cur_sat   = sat_q[cmd_entry];
  assign do_store  = fire && (op == OP_ADD) && !cur_sat && !hit && free_any;

  sharer_slot_match #(
    .K_SLOTS (K_SLOTS),
    .PTR_W   (PTR_W),
    .SLOT_W  (SLOT_W)
  ) match_i (
    .slot_ids (cur_ids),
    .slot_vld (cur_vld),
    .core     (cmd_core),
    .hit_vec  (hit_vec),
    .hit      (hit),
    .free_any (free_any),
    .free_idx (free_idx)
  );

  sharer_target_mask #(
    .N_CORES (N_CORES),
    .K_SLOTS (K_SLOTS),
    .PTR_W   (PTR_W)
  ) mask_i (
    .slot_ids  (cur_ids),
    .slot_vld  (cur_vld),
    .saturated (cur_sat),
    .skip      (cmd_skip),
    .requester (cmd_core),
    .mask      (list_mask)
  );

  sharer_enum_seq #(
    .N_CORES (N_CORES),
    .PTR_W   (PTR_W),
    .CNT_W   (CNT_W)
  ) seq_i (
    .clk        (clk),
    .rst        (rst),
    .load       (fire && (op == OP_LIST)),
    .load_mask  (list_mask),
    .tgt_ready  (tgt_ready),
    .tgt_valid  (tgt_valid),
    .tgt_id     (tgt_id),
    .busy       (seq_busy),
    .done       (done),
    .done_count (done_count)
  );

  // Pointer payload: no reset, one slot written per cycle.
  always_ff @(posedge clk) begin
    if (do_store) ids_q[cmd_entry][free_idx] <= cmd_core;
  end

  // Slot valid bits and saturation flags.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int e = 0; e < N_ENTRIES; e++) vld_q[e] <= '0;
      sat_q <= '0;
    end else if (fire) begin
      unique case (op)
        OP_ADD: begin
          if (!cur_sat && !hit) begin
            if (free_any) vld_q[cmd_entry][free_idx] <= 1'b1;
            else          sat_q[cmd_entry]           <= 1'b1;
          end
        end
        OP_DROP: vld_q[cmd_entry] <= cur_vld & ~hit_vec;
        OP_WIPE: begin
          vld_q[cmd_entry] <= '0;
          sat_q[cmd_entry] <= 1'b0;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/sharer_tracker_chk.sv
module sharer_tracker_chk #(
  parameter int N_CORES = 16,
  parameter int PTR_W   = 4,
  parameter int CNT_W   = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic [1:0]       cmd_op,
  input logic             tgt_valid,
  input logic             tgt_ready,
  input logic [PTR_W-1:0] tgt_id,
  input logic             done,
  input logic [CNT_W-1:0] done_count
);

  // R7
  tgt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    tgt_valid && !tgt_ready |=> tgt_valid && $stable(tgt_id));

  // R7
  tgt_order_chk: assert property (@(posedge clk) disable iff (rst)
    tgt_valid && tgt_ready |=> !tgt_valid || (tgt_id > $past(tgt_id)));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9
  done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !tgt_valid && (done_count <= CNT_W'(N_CORES)));

  // R10
  stream_block_chk: assert property (@(posedge clk) disable iff (rst)
    tgt_valid |-> !cmd_ready);

  // R10
  list_busy_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_ready && (cmd_op == 2'd3) |=> !cmd_ready);

endmodule

bind sharer_tracker sharer_tracker_chk #(
  .N_CORES (N_CORES),
  .PTR_W   (PTR_W),
  .CNT_W   (CNT_W)
) chk_i (
  .clk        (clk),
  .rst        (rst),
  .cmd_valid  (cmd_valid),
  .cmd_ready  (cmd_ready),
  .cmd_op     (cmd_op),
  .tgt_valid  (tgt_valid),
  .tgt_ready  (tgt_ready),
  .tgt_id     (tgt_id),
  .done       (done),
  .done_count (done_count)
);

// File: tb/sharer_tracker_tb_top.sv
`timescale 1ns/1ps
module sharer_tracker_tb_top;
  localparam int NC = 8;
  localparam int KS = 3;
  localparam int NE = 4;
  localparam int PW = 3;
  localparam int EW = 2;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [1:0]    cmd_op = '0;
  logic [EW-1:0] cmd_entry = '0;
  logic [PW-1:0] cmd_core = '0;
  logic          cmd_skip = 1'b0;
  logic          tgt_valid;
  logic          tgt_ready = 1'b0;
  logic [PW-1:0] tgt_id;
  logic          done;
  logic [CW-1:0] done_count;

  always #2 clk = ~clk;

  sharer_tracker #(.N_CORES(NC), .K_SLOTS(KS), .N_ENTRIES(NE)) dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_entry(cmd_entry), .cmd_core(cmd_core),
    .cmd_skip(cmd_skip), .tgt_valid(tgt_valid), .tgt_ready(tgt_ready),
    .tgt_id(tgt_id), .done(done), .done_count(done_count)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  logic [NC-1:0] m_set [NE];
  bit            m_sat [NE];
  int unsigned   lcg = 32'h1234_5678;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int pop(input logic [NC-1:0] m);
    int n = 0;
    for (int i = 0; i < NC; i++) n += int'(m[i]);
    return n;
  endfunction

  function automatic int lowest(input logic [NC-1:0] m);
    for (int i = 0; i < NC; i++) if (m[i]) return i;
    return -1;
  endfunction

  function automatic int rnd(input int range);
    lcg = lcg * 32'd1103515245 + 32'd12345;
    return int'((lcg >> 16) % range);
  endfunction

  task automatic do_cmd(input logic [1:0] op, input int e, input int c, input bit sk);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_entry = EW'(e); cmd_core = PW'(c); cmd_skip = sk;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  // Apply record/forget/wipe to the design and to the set model.
  task automatic apply(input int op, input int e, input int c);
    do_cmd(2'(op), e, c, 1'b0);
    case (op)
      0: if (!m_sat[e] && !m_set[e][c]) begin
           if (pop(m_set[e]) < KS) m_set[e][c] = 1'b1;
           else                    m_sat[e]    = 1'b1;
         end
      1: m_set[e][c] = 1'b0;
      2: begin m_set[e] = '0; m_sat[e] = 1'b0; end
      default: ;
    endcase
  endtask

  task automatic run_list(input int e, input bit sk, input int req, input bit stall, input string tag);
    logic [NC-1:0] expm;
    logic [NC-1:0] rem;
    int got = 0;
    int ev = 0;
    bit acc;
    expm = m_sat[e] ? '1 : m_set[e];
    if (sk) expm[req] = 1'b0;
    rem = expm;
    do_cmd(2'd3, e, req, sk);
    for (int n = 0; ; n++) begin
      if (done) begin
        chk(n == ev + 1, {tag, " R9 done timing"}, n, ev + 1);
        chk(int'(done_count) == pop(expm) && got == pop(expm), {tag, " R9 count"},
            int'(done_count), pop(expm));
        break;
      end
      chk(!cmd_ready, {tag, " R10 ready low while listing"}, int'(cmd_ready), 0);
      if (tgt_valid)
        chk(rem != '0 && int'(tgt_id) == lowest(rem), {tag, " R7 target"}, int'(tgt_id), lowest(rem));
      else if (rem != '0)
        chk(1'b0, {tag, " R7 valid missing"}, 0, 1);
      tgt_ready = stall ? n[0] : 1'b1;
      acc = tgt_valid && tgt_ready;
      if (acc) begin
        rem[tgt_id] = 1'b0;
        got++;
        ev = n + 1;
      end
      @(negedge clk);
      tgt_ready = 1'b0;
      if (n > 4 * NC + 10) begin
        chk(1'b0, {tag, " R9 done missing"}, 0, 1);
        break;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    for (int e = 0; e < NE; e++) begin m_set[e] = '0; m_sat[e] = 1'b0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;

    for (int e = 0; e < NE; e++) run_list(e, 1'b0, 0, 1'b0, "R1 reset");

    apply(0, 0, 5); run_list(0, 1'b0, 0, 1'b0, "R2 one");
    apply(0, 0, 2); run_list(0, 1'b0, 0, 1'b0, "R2 two");
    apply(0, 0, 5); apply(0, 0, 5); apply(0, 0, 7);
    run_list(0, 1'b0, 0, 1'b0, "R3 duplicates");
    apply(0, 0, 1); run_list(0, 1'b0, 0, 1'b0, "R4 saturate");
    apply(1, 0, 2); run_list(0, 1'b0, 0, 1'b0, "R6 forget keeps");
    apply(0, 0, 3); run_list(0, 1'b0, 0, 1'b1, "R6 record keeps");
    apply(2, 0, 0); run_list(0, 1'b0, 0, 1'b0, "R6 wipe");
    apply(0, 0, 4); run_list(0, 1'b0, 0, 1'b0, "R6 after wipe");

    apply(0, 1, 0); apply(0, 1, 6); apply(0, 1, 3);
    apply(1, 1, 6); apply(1, 1, 1);
    run_list(1, 1'b0, 0, 1'b0, "R5 forget");
    apply(0, 1, 1); run_list(1, 1'b0, 0, 1'b0, "R5 reuse");
    apply(0, 1, 2); run_list(1, 1'b1, 4, 1'b0, "R8 saturated skip");
    run_list(1, 1'b0, 0, 1'b1, "R7 stall");

    apply(0, 2, 3); apply(0, 2, 5);
    run_list(2, 1'b1, 5, 1'b0, "R8 normal skip");
    run_list(2, 1'b1, 6, 1'b1, "R8 skip absent");
    run_list(3, 1'b0, 0, 1'b0, "R10 untouched entry");
    run_list(0, 1'b0, 0, 1'b0, "R10 entry zero");

    for (int i = 0; i < 400; i++) begin
      int r = rnd(20);
      int op = (r < 12) ? 0 : (r < 17) ? 1 : 2;
      apply(op, rnd(NE), rnd(NC));
      run_list(rnd(NE), rnd(2) == 1, rnd(NC), rnd(2) == 1, "R2 R3 R4 R5 R6 sweep");
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule